// File: doc/BRIEF.md
# Output Pixel Range Clamp and Depth Expander

This block post-processes the three colour channels of an output pixel stream. Each channel arrives as a 12-bit field with a narrower source left-aligned in it. The block can first widen 8-bit or 10-bit source data to full 12-bit precision. It does this by copying the top source bits into the vacated low bits, so that a full-scale code stays full scale. It can then limit every channel to a video range chosen by a bit-depth code. A channel-class flag selects the luma/RGB limits or the chroma limits.

The result is registered, so the output is valid exactly one cycle after the input. When no input pixel is valid, the previous output pixel is held. Every control input is sampled with the pixel it applies to.

Channel 0 occupies bits [11:0], channel 1 bits [23:12] and channel 2 bits [35:24]. With the chroma flag set, channels 0 and 2 are treated as chroma and channel 1 as luma.

Top module: `out_range_fmt`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_pix` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by one clock cycle. When `in_valid` is 1, `out_pix` shows the processed pixel in the following cycle.
- R3: While `in_valid` is 0, `out_pix` keeps its previous value.
- R4: With `exp_en` = 0, each channel passes its 12 input bits unchanged into the clamp stage. A narrower source is taken as left-aligned, with its low bits as given.
- R5: With `exp_en` = 1 and `exp_mode` = 1 (8-bit source in bits [11:4]), the expanded channel is {x[11:4], x[11:8]}, so 0xFF0 becomes 0xFFF.
- R6: With `exp_en` = 1 and `exp_mode` = 0 (10-bit source in bits [11:2]), the expanded channel is {x[11:2], x[11:10]}, so 0xFFC becomes 0xFFF.
- R7: No limiting is applied when `clamp_en` = 0, or when `clamp_fmt` is 0 (full range) or any code from 4 to 7 (code 7 is reserved for programmable limits and passes through).
- R8: With `clamp_en` = 1 and `clamp_fmt` = 1 (8 bpc), every channel is limited to at least 256. The upper limit is 3775 for luma and 3855 for chroma.
- R9: With `clamp_en` = 1 and `clamp_fmt` = 2 (10 bpc), the lower limit is 256. The upper limit is 3763 for luma and 3843 for chroma.
- R10: With `clamp_en` = 1 and `clamp_fmt` = 3 (12 bpc), the lower limit is 256. The upper limit is 3760 for luma and 3840 for chroma.
- R11: The chroma limits apply only to channels 0 and 2, and only when `ycc_sel` = 1. Channel 1 always uses the luma limits.
- R12: Expansion is applied before clamping: the clamp compares the expanded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 36 | Three 12-bit channels, channel 0 in the low bits |
| clamp_en | input | 1 | Enable range limiting |
| clamp_fmt | input | 3 | Limit depth code: 0 full, 1 8 bpc, 2 10 bpc, 3 12 bpc, others pass |
| exp_en | input | 1 | Enable depth expansion |
| exp_mode | input | 1 | 0: 10-bit source, 1: 8-bit source |
| ycc_sel | input | 1 | Treat channels 0 and 2 as chroma |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 36 | Processed pixel, three 12-bit channels |

## Verification
The assertions assume that the controls are stable, known values whenever `in_valid` is high. They also assume that `in_valid` itself is driven to a known level from reset onward. The bench keeps to this by changing every input only on the falling clock edge and by driving all inputs to defined values before reset is released. Random pixels cover the whole 12-bit range, including 0 and full scale. Every control combination, the reserved codes 4 to 7 among them, is drawn so that each limit pair and each pass-through path is reached.

// File: rtl/out_range_fmt_pkg.sv
package out_range_fmt_pkg;
    localparam int PIX_W = 12;
    localparam int N_CH  = 3;
    localparam int BUS_W = PIX_W * N_CH;

    typedef enum logic [2:0] {
        FMT_FULL  = 3'd0,
        FMT_D8    = 3'd1,
        FMT_D10   = 3'd2,
        FMT_D12   = 3'd3
    } clamp_fmt_e;

    typedef logic [PIX_W-1:0] chan_t;

    // source depth for a limited-range code; 0 means no limiting
    function automatic int fmt_depth(input logic [2:0] code);
        case (code)
            FMT_D8:  return PIX_W - 4;
            FMT_D10: return PIX_W - 2;
            FMT_D12: return PIX_W;
            default: return 0;
        endcase
    endfunction

    function automatic chan_t lim_lo(input logic [2:0] code);
        int v;
        v = 16 << (PIX_W - 8);
        if (fmt_depth(code) == 0) v = 0;
        return v[PIX_W-1:0];
    endfunction

    // top code scaled to depth d, unused low bits filled with ones
    function automatic chan_t lim_hi(input logic [2:0] code, input logic chroma);
        int d;
        int top;
        int v;
        d   = fmt_depth(code);
        top = chroma ? 240 : 235;
        if (d == 0) v = (1 << PIX_W) - 1;
        else        v = (((top << (d - 8)) + 1) << (PIX_W - d)) - 1;
        return v[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/out_range_fmt_expand.sv
module out_range_fmt_expand
    import out_range_fmt_pkg::*;
#(
    parameter int W = PIX_W
) (
    input  logic [W-1:0] din,
    input  logic         en,
    input  logic         mode,
    output logic [W-1:0] dout
);
    localparam int GAP8  = 4;
    localparam int GAP10 = 2;

    always_comb begin
        if (!en)
            dout = din;
        else if (mode)
            dout = {din[W-1:GAP8], din[W-1:W-GAP8]};
        else
            dout = {din[W-1:GAP10], din[W-1:W-GAP10]};
    end
endmodule

// File: rtl/out_range_fmt_clamp.sv
module out_range_fmt_clamp
    import out_range_fmt_pkg::*;
(
    input  chan_t       din,
    input  logic        en,
    input  logic [2:0]  code,
    input  logic        chroma,
    output chan_t       dout
);
    chan_t lo;
    chan_t hi;
    logic  active;

    always_comb begin
        lo     = lim_lo(code);
        hi     = lim_hi(code, chroma);
        active = en && (fmt_depth(code) != 0);
        if (!active)       dout = din;
        else if (din < lo) dout = lo;
        else if (din > hi) dout = hi;
        else               dout = din;
    end
endmodule

// File: rtl/out_range_fmt.sv
module out_range_fmt
    import out_range_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] in_pix,
    input  logic             clamp_en,
    input  logic [2:0]       clamp_fmt,
    input  logic             exp_en,
    input  logic             exp_mode,
    input  logic             ycc_sel,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_pix
);
    localparam int LUMA_CH = 1;

    logic [BUS_W-1:0] exp_bus;
    logic [BUS_W-1:0] clp_bus;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        localparam bit IS_CHROMA = (g != LUMA_CH);

        out_range_fmt_expand #(.W(PIX_W)) u_exp (
            .din  (in_pix[g*PIX_W +: PIX_W]),
            .en   (exp_en),
            .mode (exp_mode),
            .dout (exp_bus[g*PIX_W +: PIX_W])
        );

        out_range_fmt_clamp u_clp (
            .din    (exp_bus[g*PIX_W +: PIX_W]),
            .en     (clamp_en),
            .code   (clamp_fmt),
            .chroma (ycc_sel & IS_CHROMA),
            .dout   (clp_bus[g*PIX_W +: PIX_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_pix <= '0;
        else if (in_valid)
            out_pix <= clp_bus;
    end
endmodule

// File: rtl/out_range_fmt_chk.sv
module out_range_fmt_chk
    import out_range_fmt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [BUS_W-1:0] in_pix,
    input logic             clamp_en,
    input logic [2:0]       clamp_fmt,
    input logic             exp_en,
    input logic             exp_mode,
    input logic             out_valid,
    input logic [BUS_W-1:0] out_pix
);
    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pix));

    // R4
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !exp_en && !clamp_en) |=> out_pix == $past(in_pix));

    // R8
    lim8_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_en && clamp_fmt == 3'd1) |=>
            (out_pix[11:0]  >= 12'd256 && out_pix[11:0]  <= 12'd3855 &&
             out_pix[23:12] >= 12'd256 && out_pix[23:12] <= 12'd3775 &&
             out_pix[35:24] >= 12'd256 && out_pix[35:24] <= 12'd3855));

    // R5
    full_scale8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exp_en && exp_mode && !clamp_en && in_pix[11:0] == 12'hFF0)
            |=> out_pix[11:0] == 12'hFFF);
endmodule

bind out_range_fmt out_range_fmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .clamp_en  (clamp_en),
    .clamp_fmt (clamp_fmt),
    .exp_en    (exp_en),
    .exp_mode  (exp_mode),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/out_range_fmt_bench.sv
module out_range_fmt_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [35:0] in_pix = '0;
    logic        clamp_en = 1'b0;
    logic [2:0]  clamp_fmt = 3'd0;
    logic        exp_en = 1'b0;
    logic        exp_mode = 1'b0;
    logic        ycc_sel = 1'b0;
    logic        out_valid;
    logic [35:0] out_pix;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    out_range_fmt u_out_range_fmt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .clamp_en(clamp_en), .clamp_fmt(clamp_fmt), .exp_en(exp_en),
        .exp_mode(exp_mode), .ycc_sel(ycc_sel),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic logic [11:0] m_exp(logic [11:0] x, logic en, logic md);
        if (!en) return x;
        if (md)  return {x[11:4], x[11:8]};
        return {x[11:2], x[11:10]};
    endfunction

    function automatic logic [11:0] m_clp(logic [11:0] x, logic en, logic [2:0] f, logic c);
        logic [11:0] hi;
        if (!en) return x;
        case (f)
            3'd1: hi = c ? 12'd3855 : 12'd3775;
            3'd2: hi = c ? 12'd3843 : 12'd3763;
            3'd3: hi = c ? 12'd3840 : 12'd3760;
            default: return x;
        endcase
        if (x < 12'd256) return 12'd256;
        if (x > hi) return hi;
        return x;
    endfunction

    function automatic logic [35:0] m_pix(logic [35:0] p, logic ce, logic [2:0] f,
                                          logic ee, logic em, logic y);
        logic [35:0] r;
        for (int c = 0; c < 3; c++)
            r[c*12 +: 12] = m_clp(m_exp(p[c*12 +: 12], ee, em), ce, f, y && (c != 1));
        return r;
    endfunction

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, result captured at next posedge, checked at the following negedge
    task automatic apply(logic v, logic [35:0] p, logic ce, logic [2:0] f,
                         logic ee, logic em, logic y, string req);
        logic [35:0] prev;
        logic [35:0] want;
        prev = out_pix;
        in_valid = v; in_pix = p; clamp_en = ce; clamp_fmt = f;
        exp_en = ee; exp_mode = em; ycc_sel = y;
        want = v ? m_pix(p, ce, f, ee, em, y) : prev;
        @(negedge clk);
        check({req, " valid"}, {35'd0, out_valid}, {35'd0, v});
        check(req, out_pix, want);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4321);
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset valid", {35'd0, out_valid}, 36'd0);
        check("R1 reset pix", out_pix, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 pass-through
        apply(1, 36'h123_ABC_005, 0, 0, 0, 0, 0, "R4");
        // R5 full scale 8-bit
        apply(1, 36'hFF0_FF0_FF0, 0, 0, 1, 1, 0, "R5");
        apply(1, 36'h120_AB0_010, 0, 0, 1, 1, 0, "R5");
        // R6 full scale 10-bit
        apply(1, 36'hFFC_FFC_FFC, 0, 0, 1, 0, 0, "R6");
        apply(1, 36'h804_3A8_004, 0, 0, 1, 0, 0, "R6");
        // R3 hold
        apply(0, 36'h000_000_000, 1, 1, 0, 0, 0, "R3");
        // R7 no limit codes
        apply(1, 36'hFFF_000_FFF, 1, 0, 0, 0, 0, "R7");
        apply(1, 36'hFFF_000_FFF, 1, 7, 0, 0, 1, "R7");
        apply(1, 36'hFFF_000_FFF, 0, 1, 0, 0, 1, "R7");
        // R8 R9 R10 luma vs chroma limits
        apply(1, 36'hFFF_FFF_FFF, 1, 1, 0, 0, 1, "R8 R11");
        apply(1, 36'h000_000_000, 1, 1, 0, 0, 1, "R8");
        apply(1, 36'hFFF_FFF_FFF, 1, 2, 0, 0, 1, "R9 R11");
        apply(1, 36'hFFF_FFF_FFF, 1, 3, 0, 0, 1, "R10 R11");
        apply(1, 36'hFFF_FFF_FFF, 1, 3, 0, 0, 0, "R10");
        // R12 expansion feeds clamp
        apply(1, 36'hEB0_EB0_EB0, 1, 1, 1, 1, 0, "R12");
        apply(1, 36'hEBC_EBC_EBC, 1, 2, 1, 0, 0, "R12");

        // random R2
        for (int i = 0; i < 400; i++) begin
            logic [35:0] p;
            p = {$urandom, $urandom};
            apply(($urandom % 4) != 0, p, $urandom % 2, 3'($urandom % 8),
                  $urandom % 2, $urandom % 2, $urandom % 2, "R2 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule